// File: doc/BRIEF.md
# DMA Channel Command and Interrupt Register Bank

This block is the control face of a multi-channel DMA controller. Software reaches it over a simple single-cycle read/write bus. It posts per-channel commands (start, pause, flush) into a command register, and each channel has a 2-bit field in that register. The register can be written directly or through write-one-to-set and write-one-to-clear aliases. A mask register decides which channels may consume their pending command. When a command is consumed, the bank updates that channel's state machine and sends a one-cycle strobe to the channel engine.

The engines report back with acknowledge, done and error pulses. The error pulse carries a 3-bit cause code. Each channel has a 2-bit state and a stored error code, and both can be read through a per-channel status word. Completion and error events set bits in an interrupt status register. That register also has set, clear and mask aliases, and the unmasked bits are ORed onto a single interrupt line.

Top module: `dma_cmd_bank`

## Requirements
- R1: After reset, every register reads zero, every channel is idle (state 0) with error code 0, all strobes are low and `irq` is low.
- R2: Writing offset 0xFC0 replaces the command register. Each 1 written to 0xFC4 sets the matching command bit and each 1 written to 0xFC8 clears it. Zeros leave bits unchanged. Channel n owns bits [2n+1:2n], and the codes are 1 start, 2 pause, 3 flush.
- R3: A nonzero pending field of channel n is consumed only when both of its mask bits at offset 0xFCC (bits [2n+1:2n]) are 1. Consumption clears the field. The resulting strobe and state change appear one clock after the command and mask registers allow it.
- R4: A start command on an idle (0) or paused (3) channel moves it to start-requested (1) and pulses that channel's `ch_start` for one cycle.
- R5: An `eng_ack` in the start-requested state moves the channel to running (2). In any other state it is ignored.
- R6: A pause command on a running channel moves it to paused (3) and pulses `ch_pause`. In any other state the command is consumed with no strobe and no state change.
- R7: A flush command returns the channel to idle from any state and pulses `ch_flush`. It sets no interrupt bit.
- R8: An `eng_done` on a running channel returns it to idle and sets interrupt bit 2n. On a channel in any other state it is ignored.
- R9: An `eng_err` on a channel that is not idle returns it to idle, sets interrupt bit 2n+1 and stores the code from lane n of `eng_err_code`. The per-channel status word at 0x200+4n reads state in bits [1:0] and the stored code in bits [4:2]. An error on an idle channel is ignored.
- R10: Interrupt status (0xFD0) is read-only on the bus. It is changed through the set alias (0xFD4) and the clear alias (0xFD8), and its mask is at 0xFDC. `irq` is the OR of status AND mask, and it changes in the cycle after the write that changes either register.
- R11: When an engine event sets an interrupt bit in the same cycle that software clears it, the bit ends up set.
- R12: When a command is consumed in the same cycle as an engine event on that channel, the command decides the next state and the engine event is dropped.
- R13: Read data appears on `bus_rdata` one clock after the read cycle. Aliases that are write-only, and unmapped offsets, read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte offset |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, one cycle after the read |
| eng_ack | input | NCH | Engine accepted its start, one bit per channel |
| eng_done | input | NCH | Engine finished its transfer |
| eng_err | input | NCH | Engine failed |
| eng_err_code | input | 3*NCH | Error cause, lane n in bits [3n+2:3n] |
| ch_start | output | NCH | One-cycle start strobe |
| ch_pause | output | NCH | One-cycle pause strobe |
| ch_flush | output | NCH | One-cycle flush strobe |
| irq | output | 1 | Combined unmasked interrupt |

## Verification
The assertions take for granted that the engines only raise `eng_ack` after a start strobe. They also take for granted that engine pulses last one cycle and that at most one bus access is made per cycle. The checks cover strobe exclusivity per channel, the legal entry into running and paused, the idle state that follows a flush, and the interrupt bit left behind by a completed run. The stimulus drives every engine pulse for exactly one clock at the falling edge and issues one bus access per task. Same-cycle collisions (R11, R12) are only produced on purpose, in their own steps.

// File: rtl/dma_cmd_bank_pkg.sv
package dma_cmd_bank_pkg;

  typedef enum logic [1:0] {
    CST_IDLE  = 2'd0,
    CST_START = 2'd1,
    CST_RUN   = 2'd2,
    CST_PAUSE = 2'd3
  } chan_state_e;

  localparam logic [1:0] OP_NONE  = 2'd0;
  localparam logic [1:0] OP_START = 2'd1;
  localparam logic [1:0] OP_PAUSE = 2'd2;
  localparam logic [1:0] OP_FLUSH = 2'd3;

  localparam int unsigned ERR_W = 3;

  typedef struct packed {
    logic cmd_stat;
    logic cmd_set;
    logic cmd_clr;
    logic cmd_mask;
    logic int_set;
    logic int_clr;
    logic int_mask;
  } wr_strobes_t;

  typedef enum logic [2:0] {
    RSEL_NONE     = 3'd0,
    RSEL_CMD_STAT = 3'd1,
    RSEL_CMD_MASK = 3'd2,
    RSEL_INT_STAT = 3'd3,
    RSEL_INT_MASK = 3'd4,
    RSEL_CHAN     = 3'd5
  } rsel_e;

endpackage

// File: rtl/dma_cmd_bank_decode.sv
module dma_cmd_bank_decode
  import dma_cmd_bank_pkg::*;
#(
  parameter int unsigned AW     = 12,
  parameter int unsigned NCH    = 16,
  parameter int unsigned CIDX_W = 4,
  parameter logic [AW-1:0] CMD_BASE  = 'hFC0,
  parameter logic [AW-1:0] INT_BASE  = 'hFD0,
  parameter logic [AW-1:0] CHST_BASE = 'h200
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  output wr_strobes_t       wr,
  output rsel_e             rsel,
  output logic [CIDX_W-1:0] chan_idx
);

  localparam logic [AW-1:0] CHST_SPAN = AW'(4 * NCH);

  logic [AW-1:0] chst_off;
  logic          chst_hit;
  logic          wr_en;
  logic          rd_en;

  assign wr_en    = bus_sel && bus_wr;
  assign rd_en    = bus_sel && !bus_wr;
  assign chst_off = bus_addr - CHST_BASE;
  assign chst_hit = (bus_addr >= CHST_BASE) && (chst_off < CHST_SPAN) &&
                    (chst_off[1:0] == 2'b00);
  assign chan_idx = chst_off[CIDX_W+1:2];

  always_comb begin
    wr          = '0;
    wr.cmd_stat = wr_en && (bus_addr == CMD_BASE);
    wr.cmd_set  = wr_en && (bus_addr == CMD_BASE + AW'(4));
    wr.cmd_clr  = wr_en && (bus_addr == CMD_BASE + AW'(8));
    wr.cmd_mask = wr_en && (bus_addr == CMD_BASE + AW'(12));
    wr.int_set  = wr_en && (bus_addr == INT_BASE + AW'(4));
    wr.int_clr  = wr_en && (bus_addr == INT_BASE + AW'(8));
    wr.int_mask = wr_en && (bus_addr == INT_BASE + AW'(12));
  end

  always_comb begin
    rsel = RSEL_NONE;
    if (rd_en) begin
      if (bus_addr == CMD_BASE)                  rsel = RSEL_CMD_STAT;
      else if (bus_addr == CMD_BASE + AW'(12))   rsel = RSEL_CMD_MASK;
      else if (bus_addr == INT_BASE)             rsel = RSEL_INT_STAT;
      else if (bus_addr == INT_BASE + AW'(12))   rsel = RSEL_INT_MASK;
      else if (chst_hit)                         rsel = RSEL_CHAN;
    end
  end

endmodule

// File: rtl/dma_cmd_bank_cmdreg.sv
module dma_cmd_bank_cmdreg #(
  parameter int unsigned FW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_stat,
  input  logic          we_set,
  input  logic          we_clr,
  input  logic          we_mask,
  input  logic [FW-1:0] wdata,
  input  logic [FW-1:0] consume,
  output logic [FW-1:0] pend,
  output logic [FW-1:0] run_mask
);

  logic [FW-1:0] pend_n;
  logic [FW-1:0] mask_n;
  logic          pend_en;
  logic          mask_en;

  // consumption first, software writes after: a fresh write is never lost
  always_comb begin
    pend_n = pend & ~consume;
    if (we_stat) pend_n = wdata;
    if (we_set)  pend_n = pend_n | wdata;
    if (we_clr)  pend_n = pend_n & ~wdata;
    pend_en = we_stat || we_set || we_clr || (|consume);
  end

  always_comb begin
    mask_n  = wdata;
    mask_en = we_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
    end else if (pend_en) begin
      pend <= pend_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_mask <= '0;
    end else if (mask_en) begin
      run_mask <= mask_n;
    end
  end

endmodule

// File: rtl/dma_cmd_bank_chan.sv
module dma_cmd_bank_chan
  import dma_cmd_bank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       pend_op,
  input  logic             run_en,
  input  logic             ack,
  input  logic             done,
  input  logic             err,
  input  logic [ERR_W-1:0] err_code_in,
  output chan_state_e      state,
  output logic [ERR_W-1:0] err_code,
  output logic             take,
  output logic             pulse_start,
  output logic             pulse_pause,
  output logic             pulse_flush,
  output logic             evt_done,
  output logic             evt_err
);

  chan_state_e      state_n;
  logic [ERR_W-1:0] code_n;
  logic             state_en;
  logic             start_n;
  logic             pause_n;
  logic             flush_n;

  assign take = run_en && (pend_op != OP_NONE);

  always_comb begin
    state_n  = state;
    code_n   = err_code;
    start_n  = 1'b0;
    pause_n  = 1'b0;
    flush_n  = 1'b0;
    evt_done = 1'b0;
    evt_err  = 1'b0;
    if (take) begin
      unique case (pend_op)
        OP_START: begin
          if (state == CST_IDLE || state == CST_PAUSE) begin
            state_n = CST_START;
            start_n = 1'b1;
          end
        end
        OP_PAUSE: begin
          if (state == CST_RUN) begin
            state_n = CST_PAUSE;
            pause_n = 1'b1;
          end
        end
        OP_FLUSH: begin
          state_n = CST_IDLE;
          flush_n = 1'b1;
        end
        default: ;
      endcase
    end else if (err && state != CST_IDLE) begin
      state_n = CST_IDLE;
      code_n  = err_code_in;
      evt_err = 1'b1;
    end else begin
      unique case (state)
        CST_START: if (ack) state_n = CST_RUN;
        CST_RUN: begin
          if (done) begin
            state_n  = CST_IDLE;
            evt_done = 1'b1;
          end
        end
        default: ;
      endcase
    end
    state_en = take || err || ack || done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= CST_IDLE;
      err_code <= '0;
    end else if (state_en) begin
      state    <= state_n;
      err_code <= code_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_start <= 1'b0;
      pulse_pause <= 1'b0;
      pulse_flush <= 1'b0;
    end else begin
      pulse_start <= start_n;
      pulse_pause <= pause_n;
      pulse_flush <= flush_n;
    end
  end

endmodule

// File: rtl/dma_cmd_bank_irq.sv
module dma_cmd_bank_irq #(
  parameter int unsigned FW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_set,
  input  logic          we_clr,
  input  logic          we_mask,
  input  logic [FW-1:0] wdata,
  input  logic [FW-1:0] hw_set,
  output logic [FW-1:0] stat,
  output logic [FW-1:0] mask,
  output logic          irq
);

  logic [FW-1:0] stat_n;
  logic          stat_en;

  // hardware events are ORed in last so they win over a same-cycle clear
  always_comb begin
    stat_n = stat;
    if (we_set) stat_n = stat_n | wdata;
    if (we_clr) stat_n = stat_n & ~wdata;
    stat_n  = stat_n | hw_set;
    stat_en = we_set || we_clr || (|hw_set);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat <= '0;
    end else if (stat_en) begin
      stat <= stat_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '0;
    end else if (we_mask) begin
      mask <= wdata;
    end
  end

  assign irq = |(stat & mask);

endmodule

// File: rtl/dma_cmd_bank.sv
module dma_cmd_bank
  import dma_cmd_bank_pkg::*;
#(
  parameter int unsigned NCH = 16,
  parameter int unsigned AW  = 12,
  parameter int unsigned DW  = 32,
  parameter logic [AW-1:0] CMD_BASE  = 'hFC0,
  parameter logic [AW-1:0] INT_BASE  = 'hFD0,
  parameter logic [AW-1:0] CHST_BASE = 'h200
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [AW-1:0]      bus_addr,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  input  logic [NCH-1:0]     eng_ack,
  input  logic [NCH-1:0]     eng_done,
  input  logic [NCH-1:0]     eng_err,
  input  logic [3*NCH-1:0]   eng_err_code,
  output logic [NCH-1:0]     ch_start,
  output logic [NCH-1:0]     ch_pause,
  output logic [NCH-1:0]     ch_flush,
  output logic               irq
);

  localparam int unsigned FW     = 2 * NCH;
  localparam int unsigned CIDX_W = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int unsigned CSW    = 2 + ERR_W;

  // reset: asserted asynchronously, removed on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe[1];

  wr_strobes_t       wr;
  rsel_e             rsel;
  logic [CIDX_W-1:0] chan_idx;

  dma_cmd_bank_decode #(
    .AW(AW), .NCH(NCH), .CIDX_W(CIDX_W),
    .CMD_BASE(CMD_BASE), .INT_BASE(INT_BASE), .CHST_BASE(CHST_BASE)
  ) u_decode (
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .wr       (wr),
    .rsel     (rsel),
    .chan_idx (chan_idx)
  );

  logic [FW-1:0] cmd_pend;
  logic [FW-1:0] cmd_mask;
  logic [FW-1:0] consume;
  logic [FW-1:0] int_hw_set;
  logic [FW-1:0] int_stat;
  logic [FW-1:0] int_mask;
  logic [FW-1:0] ch_state_flat;

  dma_cmd_bank_cmdreg #(.FW(FW)) u_cmdreg (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .we_stat  (wr.cmd_stat),
    .we_set   (wr.cmd_set),
    .we_clr   (wr.cmd_clr),
    .we_mask  (wr.cmd_mask),
    .wdata    (bus_wdata[FW-1:0]),
    .consume  (consume),
    .pend     (cmd_pend),
    .run_mask (cmd_mask)
  );

  chan_state_e      st_arr  [NCH];
  logic [ERR_W-1:0] err_arr [NCH];

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    logic        take;
    logic        evt_done;
    logic        evt_err;

    dma_cmd_bank_chan u_chan (
      .clk         (clk),
      .rst_n       (rst_int_n),
      .pend_op     (cmd_pend[2*i +: 2]),
      .run_en      (&cmd_mask[2*i +: 2]),
      .ack         (eng_ack[i]),
      .done        (eng_done[i]),
      .err         (eng_err[i]),
      .err_code_in (eng_err_code[ERR_W*i +: ERR_W]),
      .state       (st_arr[i]),
      .err_code    (err_arr[i]),
      .take        (take),
      .pulse_start (ch_start[i]),
      .pulse_pause (ch_pause[i]),
      .pulse_flush (ch_flush[i]),
      .evt_done    (evt_done),
      .evt_err     (evt_err)
    );

    assign consume[2*i +: 2]       = {2{take}};
    assign int_hw_set[2*i]         = evt_done;
    assign int_hw_set[2*i + 1]     = evt_err;
    assign ch_state_flat[2*i +: 2] = st_arr[i];
  end

  dma_cmd_bank_irq #(.FW(FW)) u_irq (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .we_set  (wr.int_set),
    .we_clr  (wr.int_clr),
    .we_mask (wr.int_mask),
    .wdata   (bus_wdata[FW-1:0]),
    .hw_set  (int_hw_set),
    .stat    (int_stat),
    .mask    (int_mask),
    .irq     (irq)
  );

  // registered read path
  logic [DW-1:0] rdata_n;
  logic          rdata_en;

  always_comb begin
    rdata_n  = '0;
    rdata_en = bus_sel && !bus_wr;
    unique case (rsel)
      RSEL_CMD_STAT: rdata_n[FW-1:0]  = cmd_pend;
      RSEL_CMD_MASK: rdata_n[FW-1:0]  = cmd_mask;
      RSEL_INT_STAT: rdata_n[FW-1:0]  = int_stat;
      RSEL_INT_MASK: rdata_n[FW-1:0]  = int_mask;
      RSEL_CHAN:     rdata_n[CSW-1:0] = {err_arr[chan_idx], st_arr[chan_idx]};
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      bus_rdata <= '0;
    end else if (rdata_en) begin
      bus_rdata <= rdata_n;
    end
  end

endmodule

// File: rtl/dma_cmd_bank_chk.sv
module dma_cmd_bank_chk
  import dma_cmd_bank_pkg::*;
#(
  parameter int unsigned NCH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2*NCH-1:0] ch_state,
  input logic [NCH-1:0]   ch_start,
  input logic [NCH-1:0]   ch_pause,
  input logic [NCH-1:0]   ch_flush,
  input logic [NCH-1:0]   eng_ack,
  input logic [2*NCH-1:0] int_stat
);

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    // R3: one strobe at most per channel per cycle
    a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ch_start[i], ch_pause[i], ch_flush[i]}));

    a_r4_start_entry: assert property (@(posedge clk) disable iff (!rst_n)
      ch_start[i] |-> (ch_state[2*i +: 2] == CST_START) &&
        ($past(ch_state[2*i +: 2]) == CST_IDLE ||
         $past(ch_state[2*i +: 2]) == CST_PAUSE));

    a_r5_run_from_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_state[2*i +: 2] == CST_RUN && $past(ch_state[2*i +: 2]) != CST_RUN)
        |-> ($past(ch_state[2*i +: 2]) == CST_START) && $past(eng_ack[i]));

    a_r6_pause_entry: assert property (@(posedge clk) disable iff (!rst_n)
      ch_pause[i] |-> (ch_state[2*i +: 2] == CST_PAUSE) &&
        ($past(ch_state[2*i +: 2]) == CST_RUN));

    a_r7_flush_idle: assert property (@(posedge clk) disable iff (!rst_n)
      ch_flush[i] |-> (ch_state[2*i +: 2] == CST_IDLE));

    a_r8_leave_run_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_state[2*i +: 2] == CST_IDLE && $past(ch_state[2*i +: 2]) == CST_RUN &&
       !ch_flush[i]) |-> (int_stat[2*i] || int_stat[2*i + 1]));
  end

endmodule

bind dma_cmd_bank dma_cmd_bank_chk #(.NCH(NCH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_int_n),
  .ch_state (ch_state_flat),
  .ch_start (ch_start),
  .ch_pause (ch_pause),
  .ch_flush (ch_flush),
  .eng_ack  (eng_ack),
  .int_stat (int_stat)
);

// File: tb/dma_cmd_bank_tb.sv
`timescale 1ns/1ps
module dma_cmd_bank_tb;

  localparam int NCH = 4;
  localparam int AW  = 12;
  localparam int DW  = 32;
  localparam logic [AW-1:0] A_CSTAT = 12'hFC0;
  localparam logic [AW-1:0] A_CSET  = 12'hFC4;
  localparam logic [AW-1:0] A_CCLR  = 12'hFC8;
  localparam logic [AW-1:0] A_CMASK = 12'hFCC;
  localparam logic [AW-1:0] A_ISTAT = 12'hFD0;
  localparam logic [AW-1:0] A_ISET  = 12'hFD4;
  localparam logic [AW-1:0] A_ICLR  = 12'hFD8;
  localparam logic [AW-1:0] A_IMASK = 12'hFDC;
  localparam logic [AW-1:0] A_CHST  = 12'h200;

  logic             clk;
  logic             rst_n;
  logic             bus_sel;
  logic             bus_wr;
  logic [AW-1:0]    bus_addr;
  logic [DW-1:0]    bus_wdata;
  logic [DW-1:0]    bus_rdata;
  logic [NCH-1:0]   eng_ack;
  logic [NCH-1:0]   eng_done;
  logic [NCH-1:0]   eng_err;
  logic [3*NCH-1:0] eng_err_code;
  logic [NCH-1:0]   ch_start;
  logic [NCH-1:0]   ch_pause;
  logic [NCH-1:0]   ch_flush;
  logic             irq;

  int n_cmp;
  int n_bad;
  int cycles;

  dma_cmd_bank #(.NCH(NCH), .AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_ack(eng_ack), .eng_done(eng_done), .eng_err(eng_err),
    .eng_err_code(eng_err_code), .ch_start(ch_start), .ch_pause(ch_pause),
    .ch_flush(ch_flush), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 200000) begin
      n_cmp = n_cmp + 1;
      n_bad = n_bad + 1;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp = n_cmp + 1;
    if (act !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_check(input string tag, input logic [AW-1:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd_reg(a, d);
    check(tag, d, exp);
  endtask

  task automatic pulse(input int kind, input int ch, input logic [2:0] code);
    @(negedge clk);
    case (kind)
      0: eng_ack[ch] = 1'b1;
      1: eng_done[ch] = 1'b1;
      default: begin
        eng_err[ch] = 1'b1;
        eng_err_code[3*ch +: 3] = code;
      end
    endcase
    @(negedge clk);
    eng_ack = '0; eng_done = '0; eng_err = '0; eng_err_code = '0;
  endtask

  // command written via set alias; strobe sampled one edge later
  task automatic post_cmd(input int ch, input logic [1:0] op);
    wr_reg(A_CSET, 32'(op) << (2 * ch));
    @(negedge clk);
  endtask

  function automatic logic [31:0] chw(input int ch);
    return 32'(A_CHST) + 32'(4 * ch);
  endfunction

  initial begin
    logic [31:0] exp_v;
    n_cmp = 0; n_bad = 0; cycles = 0;
    bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    eng_ack = '0; eng_done = '0; eng_err = '0; eng_err_code = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 irq", 32'(irq), 0);
    check("R1 strobes", 32'({ch_start, ch_pause, ch_flush}), 0);
    rd_check("R1 cmd stat", A_CSTAT, 0);
    rd_check("R1 cmd mask", A_CMASK, 0);
    rd_check("R1 int stat", A_ISTAT, 0);
    rd_check("R1 int mask", A_IMASK, 0);
    for (int c = 0; c < NCH; c++) rd_check("R1 chan word", AW'(chw(c)), 0);

    // R2 sweep of direct, set and clear writes (mask 0: nothing consumed)
    for (int v = 0; v < 256; v++) begin
      logic [7:0] s;
      logic [7:0] k;
      s = 8'((v * 37) ^ 8'h5A);
      k = 8'((v * 91) + 3);
      wr_reg(A_CSTAT, 32'(v));
      rd_check("R2 direct", A_CSTAT, 32'(v));
      wr_reg(A_CSET, 32'(s));
      rd_check("R2 set", A_CSTAT, 32'(8'(v) | s));
      wr_reg(A_CCLR, 32'(k));
      rd_check("R2 clr", A_CSTAT, 32'((8'(v) | s) & ~k));
    end
    check("R3 no strobe while masked", 32'({ch_start, ch_pause, ch_flush}), 0);

    // R13 write-only aliases and unmapped offsets read zero
    rd_check("R13 set alias", A_CSET, 0);
    rd_check("R13 clr alias", A_ICLR, 0);
    rd_check("R13 unmapped", 12'h204 + 12'(4 * NCH), 0);
    rd_check("R13 misaligned", 12'h201, 0);

    // R3 mask gating: starts pending on all, enable only channel 1 fully
    wr_reg(A_CSTAT, 32'h55);
    wr_reg(A_CMASK, 32'h0D);
    @(negedge clk);
    check("R3 only ch1 start", 32'(ch_start), 32'h2);
    @(negedge clk);
    check("R4 strobe one cycle", 32'(ch_start), 0);
    rd_check("R3 pend after consume", A_CSTAT, 32'h51);
    rd_check("R4 ch1 start state", AW'(chw(1)), 1);
    rd_check("R3 ch0 held", AW'(chw(0)), 0);

    // R5 ack: ch1 moves, idle ch0 ignores
    @(negedge clk); eng_ack = 4'b0011;
    @(negedge clk); eng_ack = '0;
    rd_check("R5 ch1 running", AW'(chw(1)), 2);
    rd_check("R5 ch0 ack ignored", AW'(chw(0)), 0);

    wr_reg(A_CMASK, 32'hFF);
    @(negedge clk);
    check("R4 remaining starts", 32'(ch_start), 32'hD);
    pulse(0, 0, 0); pulse(0, 2, 0); pulse(0, 3, 0);
    for (int c = 0; c < NCH; c++) rd_check("R5 all running", AW'(chw(c)), 2);

    // R6 pause running ch2, then again on paused
    post_cmd(2, 2'd2);
    check("R6 pause strobe", 32'(ch_pause), 32'h4);
    rd_check("R6 paused", AW'(chw(2)), 3);
    post_cmd(2, 2'd2);
    check("R6 repeat pause no strobe", 32'(ch_pause), 0);
    rd_check("R6 still paused", AW'(chw(2)), 3);
    rd_check("R6 pend consumed", A_CSTAT, 0);

    // R4 resume from paused
    post_cmd(2, 2'd1);
    check("R4 resume strobe", 32'(ch_start), 32'h4);
    rd_check("R4 resume state", AW'(chw(2)), 1);
    pulse(0, 2, 0);
    rd_check("R5 resumed running", AW'(chw(2)), 2);

    // R8 completion
    pulse(1, 3, 0);
    rd_check("R8 ch3 idle", AW'(chw(3)), 0);
    rd_check("R8 done bit", A_ISTAT, 32'h40);
    check("R10 masked irq low", 32'(irq), 0);
    pulse(1, 3, 0);
    rd_check("R8 done on idle ignored", A_ISTAT, 32'h40);

    // R10 interrupt aliases
    wr_reg(A_IMASK, 32'h40);
    check("R10 irq on unmask", 32'(irq), 1);
    wr_reg(A_ICLR, 32'h40);
    check("R10 irq drops after clear", 32'(irq), 0);
    wr_reg(A_ISET, 32'h0F);
    rd_check("R10 set alias", A_ISTAT, 32'h0F);
    wr_reg(A_ISTAT, 32'hFF);
    rd_check("R10 status write ignored", A_ISTAT, 32'h0F);
    wr_reg(A_ICLR, 32'hFF);
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        logic [7:0] sv;
        logic [7:0] mv;
        sv = 8'(a * 17);
        mv = 8'(b * 15 + 1);
        wr_reg(A_ISET, 32'(sv));
        wr_reg(A_IMASK, 32'(mv));
        check("R10 irq sweep", 32'(irq), 32'(|(sv & mv)));
        wr_reg(A_ICLR, 32'hFF);
        check("R10 irq after clear", 32'(irq), 0);
      end
    end
    wr_reg(A_IMASK, 32'h00);

    // R9 error on running ch0, then on idle ch0
    pulse(2, 0, 3'd2);
    rd_check("R9 ch0 word", AW'(chw(0)), 32'h08);
    rd_check("R9 err bit", A_ISTAT, 32'h02);
    wr_reg(A_ICLR, 32'hFF);
    pulse(2, 0, 3'd5);
    rd_check("R9 idle err ignored code", AW'(chw(0)), 32'h08);
    rd_check("R9 idle err ignored bit", A_ISTAT, 0);

    // R7 flush running ch1 and idle ch3
    post_cmd(1, 2'd3);
    check("R7 flush strobe", 32'(ch_flush), 32'h2);
    rd_check("R7 ch1 idle", AW'(chw(1)), 0);
    post_cmd(3, 2'd3);
    check("R7 flush idle strobe", 32'(ch_flush), 32'h8);
    rd_check("R7 no int bit", A_ISTAT, 0);

    // R11 completion on ch2 collides with software clear of the same bit
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = A_ICLR; bus_wdata = 32'h10;
    eng_done = 4'b0100;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; eng_done = '0;
    rd_check("R11 hw set wins", A_ISTAT, 32'h10);
    wr_reg(A_ICLR, 32'hFF);

    // R12 flush consumed in the same cycle as a done on running ch2
    post_cmd(2, 2'd1);
    pulse(0, 2, 0);
    rd_check("R12 ch2 running", AW'(chw(2)), 2);
    wr_reg(A_CSET, 32'h30);
    eng_done = 4'b0100;
    @(negedge clk);
    eng_done = '0;
    check("R12 flush strobe", 32'(ch_flush), 32'h4);
    rd_check("R12 state idle", AW'(chw(2)), 0);
    rd_check("R12 done dropped", A_ISTAT, 0);

    // R6 pause on a start-requested channel is dropped
    post_cmd(3, 2'd1);
    check("R4 ch3 start", 32'(ch_start), 32'h8);
    post_cmd(3, 2'd2);
    check("R6 pause in start no strobe", 32'(ch_pause), 0);
    exp_v = 1;
    rd_check("R6 start state kept", AW'(chw(3)), exp_v);
    post_cmd(3, 2'd3);
    rd_check("R7 flush from start", AW'(chw(3)), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule